// File: doc/BRIEF.md
# Periodic interrupt and square-wave generator

This block derives a slow periodic event from a reference clock. A prescaler brings one of three reference rates down to a common 32.768 kHz step. A binary counter chain then divides that step further. A four-bit rate code picks one counter bit as the tap. Each rising edge of the tap sets a sticky periodic flag. The same tap can drive a square-wave pin with a 50% duty cycle.

The reference clock enters as a one-cycle strobe, `ref_tick_i`, in the system clock domain. Software programs the block over a small register bus. A configuration register holds the divider mode and the rate code. A control register holds the interrupt enable and the square-wave enable. A flag register reports the periodic flag and is cleared when it is read. Two divider modes hold the chain in reset. When software leaves such a mode, the chain restarts from zero, so the first event comes one half period later.

Top module: `pirq_sqw_gen`

## Requirements
- R1: After reset, all three registers read 0x00, and `sqw_o` and `irq_o` are low.
- R2: The registers are mapped as follows:
  - Address 0 (configuration): bits 6:4 are the divider mode and bits 3:0 are the rate code. Bit 7 reads 0.
  - Address 1 (control): stores all 8 bits. Bit 6 is the interrupt enable and bit 3 is the square-wave enable.
  - Address 2 (flags): read only. Writes are ignored.
  - Address 3: always reads 0.
- R3: The divider mode sets how many reference ticks make one chain step: mode 0 takes 128, mode 1 takes 32, and mode 2 takes 1.
- R4: Divider modes 6 and 7 clear the prescaler and the chain and keep them cleared. While either mode is active, `sqw_o` is low and no flag is set.
- R5: Divider modes 3, 4 and 5 freeze the prescaler and the chain. While frozen, `sqw_o` holds its value and no flag is set.
- R6: Rate code n selects chain bit k, where code 1 gives k=6, code 2 gives k=7, and codes 3 to 15 give k=n-2. Starting from a cleared chain, `sqw_o` rises after 2^k steps, then has a period of 2^(k+1) steps and stays high for half of each period.
- R7: Each rising edge of the tap sets flag bit 6, whatever the interrupt enable. Flag bit 7 and `irq_o` are both the flag ANDed with the interrupt enable.
- R8: Reading address 2 returns the flags and clears them. If a new event arrives in the same cycle as the read, the flag stays set.
- R9: `sqw_o` is low when the square-wave enable is clear or the rate code is 0. Rate code 0 never sets the flag.
- R10: Read data appears on `rdata_o` in the cycle after the read strobe. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock period |
| sel_i | input | 1 | Register bus select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Periodic interrupt request, level |
| sqw_o | output | 1 | Square-wave output |

## Verification
The hardest case to reach is a flag-register read that lands on the exact cycle of a new tap edge. Only there does the rule that setting beats clearing become visible. The bench holds the reference strobe high in the 32.768 kHz mode and uses the shortest rate code. It restarts the chain by writing the configuration register, which fixes every later event to a known cycle count after that write. It then issues back-to-back reads on the event cycle, the cycle after it, and the cycle after that. Frequency, duty cycle and first-edge delay are swept over all fifteen rate codes, and the two faster reference modes are checked as well.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [2:0] {
    DIV_FAST  = 3'd0,
    DIV_MID   = 3'd1,
    DIV_SLOW  = 3'd2,
    DIV_HOLD3 = 3'd3,
    DIV_HOLD4 = 3'd4,
    DIV_HOLD5 = 3'd5,
    DIV_CLR6  = 3'd6,
    DIV_CLR7  = 3'd7
  } div_mode_e;

  typedef enum logic [1:0] {
    ADR_CFG  = 2'd0,
    ADR_CTL  = 2'd1,
    ADR_FLG  = 2'd2,
    ADR_VOID = 2'd3
  } reg_addr_e;

  localparam int MODE_W      = 3;
  localparam int CTL_PIE_BIT = 6;
  localparam int CTL_SQW_BIT = 3;

  // chain bit tapped by a rate code; codes 1 and 2 alias to slow taps
  function automatic int tap_of_code(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              pie_o,
  output logic              sqwe_o,
  output logic              flag_o,
  output logic              irq_o
);

  localparam int CFG_W = MODE_W + RATE_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              flag_q;
  logic              wr_en, rd_en, rd_flg;

  assign wr_en  = sel_i & wr_i;
  assign rd_en  = sel_i & rd_i;
  assign rd_flg = rd_en & (reg_addr_e'(addr_i) == ADR_FLG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr_i))
        ADR_CFG: cfg_q <= wdata_i[CFG_W-1:0];
        ADR_CTL: ctl_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // a new event in the read cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (evt_i)   flag_q <= 1'b1;
    else if (rd_flg)  flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr_i))
      ADR_CFG: rd_mux[CFG_W-1:0] = cfg_q;
      ADR_CTL: rd_mux = ctl_q;
      ADR_FLG: begin
        rd_mux[DATA_W-1] = flag_q & ctl_q[CTL_PIE_BIT];
        rd_mux[DATA_W-2] = flag_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign mode_o  = cfg_q[CFG_W-1:RATE_W];
  assign rate_o  = cfg_q[RATE_W-1:0];
  assign pie_o   = ctl_q[CTL_PIE_BIT];
  assign sqwe_o  = ctl_q[CTL_SQW_BIT];
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & ctl_q[CTL_PIE_BIT];

endmodule

// File: rtl/pirq_prescale.sv
module pirq_prescale
  import pirq_pkg::*;
#(
  parameter int FAST_SH = 7,
  parameter int MID_SH  = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_tick_i,
  input  div_mode_e mode_i,
  output logic      step_o,
  output logic      clr_o
);

  localparam int PRE_W = (FAST_SH > MID_SH) ? FAST_SH : MID_SH;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;
  logic             run, wrap;

  always_comb begin
    case (mode_i)
      DIV_FAST: term = PRE_W'((1 << FAST_SH) - 1);
      DIV_MID:  term = PRE_W'((1 << MID_SH) - 1);
      default:  term = '0;
    endcase
  end

  assign run    = (mode_i == DIV_FAST) | (mode_i == DIV_MID) | (mode_i == DIV_SLOW);
  assign clr_o  = (mode_i == DIV_CLR6) | (mode_i == DIV_CLR7);
  assign wrap   = (pre_q >= term);
  assign step_o = run & ref_tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_o)             pre_q <= '0;
    else if (run && ref_tick_i) pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

endmodule

// File: rtl/pirq_chain.sv
module pirq_chain
  import pirq_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqw_en_i,
  output logic              evt_o,
  output logic              sqw_o
);

  localparam int CODES   = 1 << RATE_W;
  localparam int CHAIN_W = CODES - 2;

  logic [CHAIN_W-1:0] cnt_q;
  logic [CODES-1:0]   tap_v;
  logic [CODES-1:0]   rise_v;

  assign tap_v[0]  = 1'b0;
  assign rise_v[0] = 1'b0;

  for (genvar g = 1; g < CODES; g++) begin : g_tap
    localparam int K = tap_of_code(g);
    assign tap_v[g]  = cnt_q[K];
    // bit K flips 0->1 on the next increment
    assign rise_v[g] = ~cnt_q[K] & (&cnt_q[K-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign evt_o = step_i & rise_v[rate_i];
  assign sqw_o = sqw_en_i & tap_v[rate_i];

endmodule

// File: rtl/pirq_sqw_gen.sv
module pirq_sqw_gen
  import pirq_pkg::*;
#(
  parameter int RATE_W  = 4,
  parameter int FAST_SH = 7,
  parameter int MID_SH  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       sqw_o
);

  logic [MODE_W-1:0] mode_raw;
  logic [RATE_W-1:0] rate;
  logic              pie, sqwe, flag, evt, step, clr;
  div_mode_e         mode;

  assign mode = div_mode_e'(mode_raw);

  pirq_regs #(.DATA_W(8), .RATE_W(RATE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .evt_i   (evt),
    .rdata_o (rdata_o),
    .mode_o  (mode_raw),
    .rate_o  (rate),
    .pie_o   (pie),
    .sqwe_o  (sqwe),
    .flag_o  (flag),
    .irq_o   (irq_o)
  );

  pirq_prescale #(.FAST_SH(FAST_SH), .MID_SH(MID_SH)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .mode_i     (mode),
    .step_o     (step),
    .clr_o      (clr)
  );

  pirq_chain #(.RATE_W(RATE_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .step_i   (step),
    .rate_i   (rate),
    .sqw_en_i (sqwe),
    .evt_o    (evt),
    .sqw_o    (sqw_o)
  );

endmodule

// File: rtl/pirq_sqw_gen_chk.sv
module pirq_sqw_gen_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              rd_i,
  input logic [1:0]        addr_i,
  input logic              irq_o,
  input logic              sqw_o,
  input logic              evt,
  input logic              flag,
  input logic              pie,
  input logic              sqwe,
  input logic [RATE_W-1:0] rate,
  input logic [2:0]        mode
);

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && pie));

  p_sqw_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sqwe || rate == '0) |-> !sqw_o);

  p_rate0_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == '0) |-> !evt);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag);

  p_clear_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && addr_i == 2'd2 && !evt) |=> !flag);

  p_clr_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode[2:1] == 2'b11) |=> !sqw_o);

  p_freeze_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'd3 || mode == 3'd4 || mode == 3'd5) |-> !evt);

endmodule

bind pirq_sqw_gen pirq_sqw_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .irq_o  (irq_o),
  .sqw_o  (sqw_o),
  .evt    (evt),
  .flag   (flag),
  .pie    (pie),
  .sqwe   (sqwe),
  .rate   (rate),
  .mode   (mode_raw)
);

// File: tb/test_pirq_sqw_gen.sv
module test_pirq_sqw_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_tick_i = 1'b1;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       sqw_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pirq_sqw_gen i_pirq_sqw_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .sqw_o      (sqw_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    sel_i = 1'b1; rd_i = 1'b1; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    sel_i = 1'b0; rd_i = 1'b0;
    d = rdata_o;
  endtask

  // clear chain, set control, drop flags, release with a_val
  task automatic restart(input logic [7:0] a_val, input logic [7:0] b_val, output int w0);
    logic [7:0] tmp;
    wr_reg(2'd0, 8'h60);
    wr_reg(2'd1, b_val);
    rd_reg(2'd2, tmp);
    wr_reg(2'd0, a_val);
    w0 = cyc;
  endtask

  task automatic measure(input int w0, input int first, input int period, input string req);
    int  t1, t2, hi;
    logic prev;
    t1 = -1; t2 = -1; hi = 0; prev = sqw_o;
    for (int i = 0; i < first + 2 * period + 4; i++) begin
      @(negedge clk_i);
      if (sqw_o && !prev) begin
        if (t1 < 0) t1 = cyc;
        else if (t2 < 0) t2 = cyc;
      end
      if (t1 >= 0 && t2 < 0 && sqw_o) hi++;
      prev = sqw_o;
    end
    check(req, "first rise delay", t1 - w0, first);
    check(req, "square period", t2 - t1, period);
    check(req, "high time", hi, period / 2);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int w0, k, seen;
    logic s0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1", "sqw after reset", sqw_o, 0);
    check("R1", "irq after reset", irq_o, 0);
    for (int a = 0; a < 3; a++) begin
      rd_reg(2'(a), d);
      check("R1", "reg after reset", d, 0);
    end

    // R2 map and field widths
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, d); check("R2", "cfg bit7 reads 0", d, 8'h7F);
    wr_reg(2'd1, 8'hB7); rd_reg(2'd1, d); check("R2", "ctl readback", d, 8'hB7);
    wr_reg(2'd3, 8'h5A); rd_reg(2'd3, d); check("R2", "void addr", d, 0);
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, d); check("R2", "flag write ignored", d, 0);
    wr_reg(2'd1, 8'h00);

    // R6 sweep of every rate code in the 1-tick mode, with R7 flag and irq
    for (int code = 1; code < 16; code++) begin
      k = (code == 1) ? 6 : (code == 2) ? 7 : code - 2;
      restart(8'h20 | 8'(code), 8'h48, w0);
      measure(w0, 1 << k, 1 << (k + 1), "R6");
      check("R7", "irq with enable", irq_o, 1);
      rd_reg(2'd2, d);
      check("R7", "flags with enable", d, 8'hC0);
    end

    // R3 slower reference modes, code 3 (tap bit 1)
    restart(8'h13, 8'h08, w0);
    measure(w0, 2 * 32, 4 * 32, "R3");
    restart(8'h03, 8'h08, w0);
    measure(w0, 2 * 128, 4 * 128, "R3");

    // R7 flag sets without enable, irq stays low
    restart(8'h23, 8'h08, w0);
    seen = 0;
    repeat (12) begin @(negedge clk_i); if (irq_o) seen++; end
    check("R7", "irq without enable", seen, 0);
    rd_reg(2'd2, d);
    check("R7", "flag without enable", d, 8'h40);

    // R9 square wave disabled, code 0 silent
    restart(8'h23, 8'h40, w0);
    seen = 0;
    repeat (20) begin @(negedge clk_i); if (sqw_o) seen++; end
    check("R9", "sqw with enable clear", seen, 0);
    rd_reg(2'd2, d);
    check("R9", "flag still set", d, 8'hC0);
    restart(8'h20, 8'h48, w0);
    seen = 0;
    repeat (300) begin @(negedge clk_i); if (sqw_o || irq_o) seen++; end
    check("R9", "code 0 outputs", seen, 0);
    rd_reg(2'd2, d);
    check("R9", "code 0 flags", d, 0);

    // R4 both clearing modes
    for (int m = 0; m < 2; m++) begin
      restart(8'h23, 8'h08, w0);
      repeat (9) @(negedge clk_i);
      wr_reg(2'd0, (m == 0) ? 8'h63 : 8'h73);
      rd_reg(2'd2, d);
      seen = 0;
      repeat (40) begin @(negedge clk_i); if (sqw_o) seen++; end
      check("R4", "sqw in clear mode", seen, 0);
      rd_reg(2'd2, d);
      check("R4", "flags in clear mode", d, 0);
    end

    // R5 freeze then resume
    restart(8'h23, 8'h08, w0);
    repeat (5) @(negedge clk_i);
    wr_reg(2'd0, 8'h33);
    rd_reg(2'd2, d);
    s0 = sqw_o;
    seen = 0;
    repeat (40) begin @(negedge clk_i); if (sqw_o != s0) seen++; end
    check("R5", "sqw frozen", seen, 0);
    rd_reg(2'd2, d);
    check("R5", "flags frozen", d, 0);
    wr_reg(2'd0, 8'h23);
    repeat (8) @(negedge clk_i);
    rd_reg(2'd2, d);
    check("R5", "resumes after freeze", d, 8'h40);

    // R8 read on the event cycle: events land at w0+2, w0+6, w0+10
    restart(8'h23, 8'h00, w0);
    while (cyc != w0 + 5) @(negedge clk_i);
    rd_reg(2'd2, d); check("R8", "read on event cycle", d, 8'h40);
    rd_reg(2'd2, d); check("R8", "set wins over clear", d, 8'h40);
    rd_reg(2'd2, d); check("R8", "cleared by read", d, 0);
    repeat (4) @(negedge clk_i);
    check("R10", "rdata holds between reads", rdata_o, 0);
    rd_reg(2'd2, d); check("R10", "next read sees new flag", d, 8'h40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule